// File: doc/BRIEF.md
# Dual-Lane Four-Channel Serial Audio Receiver

This block takes in stereo audio over a serial link in the I2S style. The link has one bit clock, one word-select line and two data lanes. The front lane carries the front left and right samples. The rear lane carries the rear left and right samples. Both lanes are framed by the same word-select signal. The block rebuilds one 18-bit sample per channel and releases the four samples together as a single aligned set.

The whole block runs on the rising edge of the bit clock. Word select low marks a left slot and word select high marks a right slot. The first bit sampled after word select changes is the last bit of the word that just ended. The next bit is the most significant bit of the new word. When the right words on both lanes have finished, a registered bank updates all four outputs at once and raises a one-cycle strobe. Slots may be longer or shorter than 18 bits; a long word is cut off and a short word is padded with zeros at the bottom.

Top module: `i2s_quad_rx`

## Requirements
- R1: A synchronous active-high reset clears all four output words to zero and holds `frame_valid` low.
- R2: Samples taken while word select is low (0) form the left word, and samples taken while it is high (1) form the right word. `frame_valid` rises only in the cycle after word select falls from 1 to 0, which is where a right word ends.
- R3: Bits are received most significant bit first. The first bit of a word is the one sampled on the edge after word select changes. The bit sampled on the edge where word select is first seen changed is the last bit of the previous word.
- R4: Each word is 18 bits. Any bits beyond the 18th in a slot are dropped, so the output holds the first 18 bits received.
- R5: A slot shorter than 18 bits gives a word whose received bits are in the top positions and whose missing low bits are zero.
- R6: The front lane feeds `fl_word` (left) and `fr_word` (right). The rear lane feeds `rl_word` (left) and `rr_word` (right).
- R7: `frame_valid` is a pulse one clock long, raised in the cycle after the edge that completes the right words. All four words change together on that edge and hold their values in every other cycle.
- R8: After reset, no pulse appears until a full left word that began at a word-select change has been received, followed by the matching right word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous bit clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ws | input | 1 | Word select: 0 for a left slot, 1 for a right slot |
| sd_front | input | 1 | Serial data for the front left/right pair |
| sd_rear | input | 1 | Serial data for the rear left/right pair |
| fl_word | output | 18 | Front-left sample |
| fr_word | output | 18 | Front-right sample |
| rl_word | output | 18 | Rear-left sample |
| rr_word | output | 18 | Rear-right sample |
| frame_valid | output | 1 | One-cycle strobe when a new set of four words is presented |

## Verification
The assertions assume three things about the inputs:
- Word select and both data lines are held steady around each rising bit-clock edge.
- Reset lasts at least one clock.
- Every slot is at least one bit long, so two right-word endings are always at least two cycles apart. The single-pulse and falling-edge checks depend on this.

The stimulus meets these assumptions by changing every input only on the falling edge. It holds reset for several cycles. It uses slot lengths from 2 to 32 bits, including slots shorter and longer than the 18-bit word, so the truncation and zero-fill paths are both exercised.

// File: rtl/i2s4_pkg.sv
package i2s4_pkg;
  parameter int unsigned SAMPLE_W = 18;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/i2s4_slot_timer.sv
module i2s4_slot_timer
  import i2s4_pkg::*;
#(
  parameter int unsigned W  = SAMPLE_W,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ws,
  output chan_e         cur_chan,
  output logic          slot_end,
  output logic [CW-1:0] bit_pos,
  output logic          bit_live
);
  localparam logic [CW-1:0] POS_MAX = CW'(W);

  logic ws_q;

  // The bit sampled on this edge belongs to the slot selected on the previous edge.
  assign cur_chan = chan_e'(ws_q);
  assign slot_end = (ws != ws_q);
  assign bit_live = (bit_pos < POS_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q    <= 1'b0;
      bit_pos <= '0;
    end else begin
      ws_q <= ws;
      if (slot_end)
        bit_pos <= '0;
      else if (bit_pos != POS_MAX)
        bit_pos <= bit_pos + 1'b1;
    end
  end

  // R4: the in-slot bit position saturates at the word width
  assert_pos_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    bit_pos <= POS_MAX);

  // R3: a new slot starts counting from its first bit
  assert_restart_after_edge_R3: assert property (@(posedge clk) disable iff (rst)
    slot_end |=> (bit_pos == '0));
endmodule

// File: rtl/i2s4_lane_deser.sv
module i2s4_lane_deser
  import i2s4_pkg::*;
#(
  parameter int unsigned W  = SAMPLE_W,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sd,
  input  chan_e         cur_chan,
  input  logic          slot_end,
  input  logic [CW-1:0] bit_pos,
  input  logic          bit_live,
  output logic [W-1:0]  left_word,
  output logic [W-1:0]  word_now
);
  localparam int unsigned TOP_BIT = W - 1;

  logic [W-1:0] acc;
  logic [W-1:0] sd_vec;
  logic [W-1:0] ins;

  // Drop the sampled bit into its MSB-first position; nothing is added past the last bit.
  assign sd_vec   = {{(W-1){1'b0}}, sd};
  assign ins      = bit_live ? (sd_vec << (TOP_BIT - 32'(bit_pos))) : '0;
  assign word_now = acc | ins;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      left_word <= '0;
    end else if (slot_end) begin
      acc <= '0;
      if (cur_chan == CH_LEFT)
        left_word <= word_now;
    end else begin
      acc <= word_now;
    end
  end

  // R4: bits past the word width leave the partial word untouched
  assert_excess_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (!bit_live && !slot_end) |=> $stable(acc));
endmodule

// File: rtl/i2s_quad_rx.sv
module i2s_quad_rx
  import i2s4_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ws,
  input  logic         sd_front,
  input  logic         sd_rear,
  output logic [W-1:0] fl_word,
  output logic [W-1:0] fr_word,
  output logic [W-1:0] rl_word,
  output logic [W-1:0] rr_word,
  output logic         frame_valid
);
  localparam int unsigned CW    = $clog2(W + 1);
  localparam int unsigned LANES = 2;

  chan_e         cur_chan;
  logic          slot_end;
  logic [CW-1:0] bit_pos;
  logic          bit_live;

  logic [LANES-1:0] sd_bus;
  logic [W-1:0]     left_w [LANES];
  logic [W-1:0]     now_w  [LANES];

  logic seen_edge;
  logic left_ok;
  logic frame_fire;

  assign sd_bus = {sd_rear, sd_front};

  i2s4_slot_timer #(.W(W), .CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .ws       (ws),
    .cur_chan (cur_chan),
    .slot_end (slot_end),
    .bit_pos  (bit_pos),
    .bit_live (bit_live)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    i2s4_lane_deser #(.W(W), .CW(CW)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .sd        (sd_bus[g]),
      .cur_chan  (cur_chan),
      .slot_end  (slot_end),
      .bit_pos   (bit_pos),
      .bit_live  (bit_live),
      .left_word (left_w[g]),
      .word_now  (now_w[g])
    );
  end

  // Framing: a left word counts only if it began at a word-select change.
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_edge <= 1'b0;
      left_ok   <= 1'b0;
    end else if (slot_end) begin
      seen_edge <= 1'b1;
      if (cur_chan == CH_LEFT && seen_edge)
        left_ok <= 1'b1;
    end
  end

  assign frame_fire = slot_end && (cur_chan == CH_RIGHT) && left_ok;

  // Registered output bank: all four words move on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      fl_word     <= '0;
      fr_word     <= '0;
      rl_word     <= '0;
      rr_word     <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= frame_fire;
      if (frame_fire) begin
        fl_word <= left_w[0];
        fr_word <= now_w[0];
        rl_word <= left_w[1];
        rr_word <= now_w[1];
      end
    end
  end

  // R7: strobe lasts exactly one cycle
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  // R7: outputs hold between strobes
  assert_words_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> $stable({fl_word, fr_word, rl_word, rr_word}));

  // R2: strobe only follows a high-to-low word-select change
  assert_fire_on_right_end_R2: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> (!$past(ws) && $past(ws, 2)));
endmodule

// File: tb/sim_i2s_quad_rx.sv
`timescale 1ns/1ps
module sim_i2s_quad_rx;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ws = 1'b0;
  logic sd_front = 1'b0;
  logic sd_rear = 1'b0;
  logic [W-1:0] fl_word, fr_word, rl_word, rr_word;
  logic frame_valid;

  int vectors = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  bit pf = 1'b0, pr = 1'b0;

  always #5 clk = ~clk;

  i2s_quad_rx u0 (
    .clk(clk), .rst(rst), .ws(ws), .sd_front(sd_front), .sd_rear(sd_rear),
    .fl_word(fl_word), .fr_word(fr_word), .rl_word(rl_word), .rr_word(rr_word),
    .frame_valid(frame_valid)
  );

  // Behavioural reference model, built from the requirements
  int        m_cnt;
  bit        m_wsd, m_seen, m_lok;
  bit [17:0] m_acc [2];
  bit [17:0] m_left [2];
  bit [17:0] e_fl, e_fr, e_rl, e_rr;
  bit        e_v;

  always @(posedge clk) begin
    bit sd_now [2];
    sd_now[0] = sd_front;
    sd_now[1] = sd_rear;
    if (rst) begin
      m_cnt = 0; m_wsd = 0; m_seen = 0; m_lok = 0;
      for (int i = 0; i < 2; i++) begin m_acc[i] = '0; m_left[i] = '0; end
      e_fl = '0; e_fr = '0; e_rl = '0; e_rr = '0; e_v = 0;
    end else begin
      e_v = 0;
      if (m_cnt < W)
        for (int i = 0; i < 2; i++) m_acc[i][W-1-m_cnt] = sd_now[i];
      m_cnt++;
      if (ws != m_wsd) begin
        if (!m_wsd) begin
          if (m_seen) m_lok = 1;
          for (int i = 0; i < 2; i++) m_left[i] = m_acc[i];
        end else if (m_lok) begin
          e_fl = m_left[0]; e_fr = m_acc[0];
          e_rl = m_left[1]; e_rr = m_acc[1];
          e_v = 1;
        end
        m_seen = 1;
        for (int i = 0; i < 2; i++) m_acc[i] = '0;
        m_cnt = 0;
      end
      m_wsd = ws;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  task automatic compare_model();
    chk("R7 strobe", 32'(frame_valid), 32'(e_v));
    chk("R6 front-left", 32'(fl_word), 32'(e_fl));
    chk("R6 front-right", 32'(fr_word), 32'(e_fr));
    chk("R6 rear-left", 32'(rl_word), 32'(e_rl));
    chk("R6 rear-right", 32'(rr_word), 32'(e_rr));
  endtask

  task automatic step(bit w, bit f, bit r);
    @(negedge clk);
    compare_model();
    if (frame_valid) pulses++;
    ws = w; sd_front = f; sd_rear = r;
  endtask

  // One slot of length L; the word's LSB is sent in the next slot's first cycle.
  task automatic run_slot(bit w, int L, logic [31:0] vf, logic [31:0] vr);
    for (int c = 0; c < L; c++) begin
      if (c == 0) step(w, pf, pr);
      else        step(w, vf[L-c], vr[L-c]);
    end
    pf = vf[0];
    pr = vr[0];
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 valid", 32'(frame_valid), 32'd0);
    chk("R1 words", {14'd0, fl_word} | {14'd0, fr_word} | {14'd0, rl_word} | {14'd0, rr_word}, 32'd0);
    rst = 1'b0;

    // R8: the first left slot has no word-select change before it, and the first right word has no valid left
    run_slot(1'b0, 18, 32'h15555, 32'h0AAAA);
    run_slot(1'b1, 18, 32'h3FFFF, 32'h12345);
    chk("R8 no early strobe", 32'(pulses), 32'd0);

    // R3/R2/R6: directed 18-bit frame
    run_slot(1'b0, 18, 32'h2D3C5, 32'h3F001);
    run_slot(1'b1, 18, 32'h1A0F3, 32'h00ABC);
    chk("R8 still no strobe before right end", 32'(pulses), 32'd0);
    step(1'b0, pf, pr);
    @(negedge clk);
    chk("R7 strobe raised", 32'(frame_valid), 32'd1);
    chk("R3 front-left msb first", 32'(fl_word), 32'h2D3C5);
    chk("R2 front-right", 32'(fr_word), 32'h1A0F3);
    chk("R6 rear-left", 32'(rl_word), 32'h3F001);
    chk("R6 rear-right", 32'(rr_word), 32'h00ABC);

    // R4 long slot / R5 short slot (the left slot of this frame already began above)
    for (int c = 1; c < 24; c++) begin
      ws = 1'b0;
      sd_front = 1'(32'hABCDEF >> (24 - c));
      sd_rear  = 1'(32'h123456 >> (24 - c));
      @(negedge clk);
      compare_model();
    end
    pf = 1'b1; pr = 1'b0;
    run_slot(1'b1, 12, 32'hF0F, 32'h5A5);
    step(1'b0, pf, pr);
    @(negedge clk);
    chk("R7 strobe long/short", 32'(frame_valid), 32'd1);
    chk("R4 extra bits dropped", 32'(fl_word), 32'hABCDEF >> 6);
    chk("R4 extra bits dropped rear", 32'(rl_word), 32'h123456 >> 6);
    chk("R5 zero fill", 32'(fr_word), 32'hF0F << 6);
    chk("R5 zero fill rear", 32'(rr_word), 32'h5A5 << 6);
    @(negedge clk);
    chk("R7 strobe drops", 32'(frame_valid), 32'd0);
    compare_model();
    // finish this left slot, then random frames checked every cycle
    for (int c = 2; c < 16; c++) step(1'b0, 1'($urandom), 1'($urandom));
    pf = 1'($urandom); pr = 1'($urandom);
    for (int k = 0; k < 60; k++) begin
      int lens [7] = '{2, 12, 16, 17, 18, 20, 32};
      run_slot(1'b0, lens[$urandom % 7], $urandom, $urandom);
      run_slot(1'b1, lens[$urandom % 7], $urandom, $urandom);
    end
    step(1'b0, pf, pr);
    step(1'b0, 1'b0, 1'b0);
    chk("R7 strobes seen", 32'(pulses > 40), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule